// File: doc/BRIEF.md
# Adaptive Threshold Data Slicer

This block makes the hard one-bit decision for each received symbol of a frequency-discriminated radio link. It takes signed baseband samples, already filtered, and uses a mid-bit strobe from a clock recovery unit outside the block. At each strobe it compares the current sample with an adaptive threshold and registers the result. The registered bit then stays steady until the next strobe, so a downstream receiver can latch it on the recovered clock edge.

The threshold is not fixed. Two peak trackers follow the most positive and the most negative strobed samples. Each one attacks at once and leaks back toward zero slowly. The leak is fast while the acquire input is high and slow while it is low. The midpoint of the two peaks gives a base level that follows both the signal amplitude and any DC offset. The base is then moved toward the level of the previously decided bit, by a fraction of the peak-to-peak span. This cancels the intersymbol interference of a Gaussian-filtered signal. The fraction is set by a two-way bandwidth-time select.

Top module: `adaptive_slicer`

## Requirements
- R1: While reset is held, data_o is 0, thresh_o is 0, both peak trackers hold 0 and the previous-bit history is 0.
- R2: On a strobe, data_o takes 1 when the sample is strictly greater than thresh_o in that cycle, and 0 otherwise; a sample equal to the threshold decides 0. Just after reset the threshold is 0, so positive samples decide 1 and zero or negative samples decide 0.
- R3: On a strobe, the positive peak takes the sample if the sample is larger than the peak. Otherwise the peak becomes P - floor(P / 2^k).
- R4: On a strobe, the negative peak takes the sample if the sample is smaller than the peak. Otherwise the peak becomes N - floor(N / 2^k), with floor rounding toward minus infinity.
- R5: The base threshold is floor((P + N) / 2), computed from the peak values after the latest strobe.
- R6: thresh_o is the base plus floor((P - N) / 2^s) when the last decided bit is 1, and the base minus that amount when it is 0. s is 3 when bt_sel_i is 0 (BT 0.5) and 2 when bt_sel_i is 1 (BT 0.3).
- R7: The leak shift k is 4 when acquire_i is 1 at the strobe and 8 when it is 0.
- R8: data_o changes only in the cycle after a strobe. Samples presented without a strobe change neither data_o nor thresh_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 8 | Filtered baseband sample, two's complement, bias at zero |
| strobe_i | input | 1 | Mid-bit strobe, one cycle per received bit |
| acquire_i | input | 1 | 1 = fast peak leak (acquire), 0 = slow leak (hold) |
| bt_sel_i | input | 1 | 0 = BT 0.5 correction (span/8), 1 = BT 0.3 correction (span/4) |
| data_o | output | 1 | Registered bit decision |
| thresh_o | output | 8 | Threshold that the next strobe will use, two's complement |

## Verification
A single strobed sample is swept over every 8-bit value straight after reset. This separates the sign convention and the tie at zero from any adaptive effect. Alternating full-swing bits with no offset check the symmetric threshold and the sign of the ISI shift. A lopsided pattern with a DC offset shows whether the base follows the midpoint of the peaks and not zero, and repeating it with the other bandwidth setting shows the two correction fractions apart. A large burst followed by weak samples, first in acquire and then in hold, checks the two leak rates, and samples placed exactly on the threshold check the strict comparison.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
   // Polarity of a peak tracker: which extreme of the signal it follows
   typedef enum logic {
      PK_POS = 1'b0,
      PK_NEG = 1'b1
   } peak_pol_e;

   // Correction fraction selector values
   typedef enum logic {
      BT_WIDE   = 1'b0,
      BT_NARROW = 1'b1
   } bt_sel_e;
endpackage

// File: rtl/slicer_peak_tracker.sv
module slicer_peak_tracker
   import slicer_pkg::*;
#(
   parameter int        W       = 8,
   parameter int        ACQ_SH  = 4,
   parameter int        HOLD_SH = 8,
   parameter peak_pol_e POL     = PK_POS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                acquire,
   input  logic signed [W-1:0] sample,
   output logic signed [W-1:0] peak
);
   logic signed [W-1:0] leak;
   logic signed [W-1:0] decayed;
   logic signed [W-1:0] nxt;
   logic                attack;

   if (ACQ_SH < 1 || ACQ_SH >= W + 1) begin : g_bad_acq
      $error("slicer_peak_tracker: ACQ_SH out of range");
   end
   if (HOLD_SH < 1 || HOLD_SH >= W + 1) begin : g_bad_hold
      $error("slicer_peak_tracker: HOLD_SH out of range");
   end

   // Leak toward zero: arithmetic shift floors, so negative peaks rise
   always_comb begin
      leak    = acquire ? (peak >>> ACQ_SH) : (peak >>> HOLD_SH);
      decayed = peak - leak;
   end

   if (POL == PK_POS) begin : g_pos
      assign attack = (sample > peak);
   end else begin : g_neg
      assign attack = (sample < peak);
   end

   assign nxt = attack ? sample : decayed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak <= '0;
      end else if (en) begin
         peak <= nxt;
      end
   end
endmodule

// File: rtl/slicer_isi_threshold.sv
module slicer_isi_threshold
   import slicer_pkg::*;
#(
   parameter int W          = 8,
   parameter int SH_WIDE    = 3,
   parameter int SH_NARROW  = 2
) (
   input  logic signed [W-1:0] pos_pk,
   input  logic signed [W-1:0] neg_pk,
   input  logic                prev_bit,
   input  logic                bt_sel,
   output logic signed [W-1:0] thr
);
   localparam int XW = W + 1;
   localparam int AW = W + 2;
   localparam logic signed [AW-1:0] MAXV = AW'((2 ** (W - 1)) - 1);
   localparam logic signed [AW-1:0] MINV = AW'(-(2 ** (W - 1)));

   if (SH_WIDE < 1 || SH_NARROW < 1 || SH_WIDE > W || SH_NARROW > W) begin : g_bad_sh
      $error("slicer_isi_threshold: correction shift out of range");
   end

   logic signed [XW-1:0] pos_x;
   logic signed [XW-1:0] neg_x;
   logic signed [XW-1:0] sum_x;
   logic signed [XW-1:0] span_x;
   logic signed [XW-1:0] base_x;
   logic signed [XW-1:0] off_x;
   logic signed [AW-1:0] adj;

   always_comb begin
      pos_x  = {pos_pk[W-1], pos_pk};
      neg_x  = {neg_pk[W-1], neg_pk};
      sum_x  = pos_x + neg_x;
      span_x = pos_x - neg_x;
      base_x = sum_x >>> 1;
      off_x  = (bt_sel == BT_NARROW) ? (span_x >>> SH_NARROW) : (span_x >>> SH_WIDE);
      if (prev_bit) begin
         adj = {base_x[XW-1], base_x} + {off_x[XW-1], off_x};
      end else begin
         adj = {base_x[XW-1], base_x} - {off_x[XW-1], off_x};
      end
      if (adj > MAXV) begin
         thr = MAXV[W-1:0];
      end else if (adj < MINV) begin
         thr = MINV[W-1:0];
      end else begin
         thr = adj[W-1:0];
      end
   end
endmodule

// File: rtl/slicer_bit_decider.sv
module slicer_bit_decider #(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strobe,
   input  logic signed [W-1:0] sample,
   input  logic signed [W-1:0] thr,
   output logic                bit_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
      end else if (strobe) begin
         bit_q <= (sample > thr);
      end
   end
endmodule

// File: rtl/adaptive_slicer.sv
module adaptive_slicer
   import slicer_pkg::*;
#(
   parameter int SAMPLE_W     = 8,
   parameter int LEAK_ACQ_SH  = 4,
   parameter int LEAK_HOLD_SH = 8,
   parameter int ISI_SH_WIDE  = 3,
   parameter int ISI_SH_NARR  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic signed [SAMPLE_W-1:0] sample_i,
   input  logic                       strobe_i,
   input  logic                       acquire_i,
   input  logic                       bt_sel_i,
   output logic                       data_o,
   output logic signed [SAMPLE_W-1:0] thresh_o
);
   if (SAMPLE_W < 4) begin : g_bad_w
      $error("adaptive_slicer: SAMPLE_W must be at least 4");
   end
   if (LEAK_HOLD_SH <= LEAK_ACQ_SH) begin : g_bad_leak
      $error("adaptive_slicer: hold leak must be slower than acquire leak");
   end

   logic signed [SAMPLE_W-1:0] pos_pk;
   logic signed [SAMPLE_W-1:0] neg_pk;

   slicer_peak_tracker #(
      .W(SAMPLE_W), .ACQ_SH(LEAK_ACQ_SH), .HOLD_SH(LEAK_HOLD_SH), .POL(PK_POS)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .en(strobe_i), .acquire(acquire_i),
      .sample(sample_i), .peak(pos_pk)
   );

   slicer_peak_tracker #(
      .W(SAMPLE_W), .ACQ_SH(LEAK_ACQ_SH), .HOLD_SH(LEAK_HOLD_SH), .POL(PK_NEG)
   ) u_neg (
      .clk(clk), .rst_n(rst_n), .en(strobe_i), .acquire(acquire_i),
      .sample(sample_i), .peak(neg_pk)
   );

   slicer_isi_threshold #(
      .W(SAMPLE_W), .SH_WIDE(ISI_SH_WIDE), .SH_NARROW(ISI_SH_NARR)
   ) u_thr (
      .pos_pk(pos_pk), .neg_pk(neg_pk), .prev_bit(data_o),
      .bt_sel(bt_sel_i), .thr(thresh_o)
   );

   slicer_bit_decider #(
      .W(SAMPLE_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .strobe(strobe_i),
      .sample(sample_i), .thr(thresh_o), .bit_q(data_o)
   );
endmodule

// File: rtl/adaptive_slicer_chk.sv
module adaptive_slicer_chk #(
   parameter int W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic signed [W-1:0] sample_i,
   input logic                strobe_i,
   input logic                data_o,
   input logic signed [W-1:0] thresh_o,
   input logic signed [W-1:0] pos_pk,
   input logic signed [W-1:0] neg_pk
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |-> (data_o == 1'b0 && thresh_o == '0 && pos_pk == '0 && neg_pk == '0));

   // R2
   decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> (data_o == ($past(sample_i) > $past(thresh_o))));

   // R3
   pos_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && sample_i > pos_pk) |=> (pos_pk == $past(sample_i)));

   // R4
   neg_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && sample_i < neg_pk) |=> (neg_pk == $past(sample_i)));

   // R3
   pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_pk[W-1]);

   // R4
   neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (neg_pk[W-1] || neg_pk == '0));

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> $stable(data_o));

   // R8
   peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> ($stable(pos_pk) && $stable(neg_pk)));
endmodule

bind adaptive_slicer adaptive_slicer_chk #(.W(SAMPLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .strobe_i(strobe_i),
   .data_o(data_o), .thresh_o(thresh_o), .pos_pk(pos_pk), .neg_pk(neg_pk)
);

// File: tb/tb_adaptive_slicer.sv
module tb_adaptive_slicer;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic signed [7:0] sample;
   logic              strobe;
   logic              acq;
   logic              bt;
   logic              data;
   logic signed [7:0] thr;

   int errors = 0;
   int checks = 0;
   int mP, mN, mPrev;

   adaptive_slicer dut (
      .clk(clk), .rst_n(rst_n), .sample_i(sample), .strobe_i(strobe),
      .acquire_i(acq), .bt_sel_i(bt), .data_o(data), .thresh_o(thr)
   );

   function automatic int model_thr();
      int sh, base, off;
      sh   = bt ? 2 : 3;
      base = (mP + mN) >>> 1;
      off  = (mP - mN) >>> sh;
      return mPrev ? base + off : base - off;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n  = 1'b0;
      strobe = 1'b0;
      sample = '0;
      repeat (2) @(negedge clk);
      check("R1 data in reset", int'(data), 0);
      check("R1 thresh in reset", int'(thr), 0);
      rst_n = 1'b1;
      mP = 0; mN = 0; mPrev = 0;
      @(negedge clk);
   endtask

   // One strobed bit, then idle cycles with junk samples (R8)
   task automatic send(int s, string tag);
      int t, exp_d, k;
      t      = model_thr();
      exp_d  = (s > t) ? 1 : 0;
      sample = 8'(s);
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      k = acq ? 4 : 8;
      if (s > mP) mP = s; else mP = mP - (mP >>> k);
      if (s < mN) mN = s; else mN = mN - (mN >>> k);
      mPrev = exp_d;
      check({tag, " R2 data"}, int'(data), exp_d);
      check({tag, " R5/R6 thresh"}, int'(thr), model_thr());
      sample = 8'(-s - 3);
      repeat (2) @(negedge clk);
      check("R8 data held", int'(data), exp_d);
      check("R8 thresh held", int'(thr), model_thr());
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      acq = 1'b0;
      bt  = 1'b0;
      do_reset();

      // R2: every sample value from a cleared state, threshold 0
      for (int s = -128; s <= 127; s++) begin
         do_reset();
         send(s, "R2 sweep");
      end

      // R6 symmetric full swing, BT 0.5
      do_reset();
      for (int i = 0; i < 24; i++) send((i % 2) ? -100 : 100, "R6 alt");
      // R2 tie: sample exactly on threshold decides 0
      send(model_thr(), "R2 tie");
      send(model_thr() + 1, "R2 above");

      // R5: DC offset, pattern 1100, BT 0.5
      do_reset();
      for (int i = 0; i < 32; i++) send(((i / 2) % 2) ? -20 : 80, "R5 offset");

      // R6: same with BT 0.3
      do_reset();
      bt = 1'b1;
      for (int i = 0; i < 32; i++) send(((i / 2) % 2) ? -20 : 80, "R6 bt03");
      send(model_thr(), "R2 tie bt03");
      bt = 1'b0;

      // R3/R4/R7: big burst then weak samples, acquire leak then hold leak
      do_reset();
      acq = 1'b1;
      send(120, "R3 attack");
      send(-110, "R4 attack");
      for (int i = 0; i < 30; i++) send((i % 2) ? -15 : 25, "R7 acquire leak");
      send(120, "R3 reattack");
      send(-110, "R4 reattack");
      acq = 1'b0;
      for (int i = 0; i < 30; i++) send((i % 2) ? -15 : 25, "R7 hold leak");

      // R3/R4 mixed settings
      acq = 1'b1;
      bt  = 1'b1;
      for (int i = 0; i < 40; i++) send(((i * 37) % 201) - 100, "R4 mixed");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule